// File: doc/BRIEF.md
# Oscillation Stop Failover Controller

This block runs on the internal oscillator and watches a main clock that reaches it as a raw level. The level passes through a synchronizer, and each rising edge restarts an idle counter. If the counter runs out before another edge arrives, the block raises a stop flag. In the same cycle it moves the system clock selection over to the internal oscillator. It also emits a one-cycle pulse, which an external interrupt controller can take. Once the main clock has delivered a fixed number of edges again, the stop flag clears. The clock selection does not move back by itself: software must return it to the main clock.

Software controls the block through one 8-bit control/status register, gated by a separate unlock input. The register holds three things: a 2-bit detection-enable code, the clock-select bit and the read-only stop flag. Whenever the internal oscillator is selected, the block also forces that oscillator's stop control to "keep running". The block has no data stream, so it has no valid/ready handshake. All of its pins are plain control and status levels. A write is a single-cycle strobe, and the read value is always present.

Top module: `osf_failover_top`

## Requirements
- R1: After reset the register reads 0x04: detection code 00, clock-select 1 (internal oscillator), stop flag 0. The switchover pulse is 0.
- R2: A write strobe takes effect only when `wr_unlock` is 1 in the same cycle. When it is 0, the write changes nothing.
- R3: Register layout: bits [1:0] are the detection code, bit 2 is clock-select and bit 3 is the stop flag. Bits [7:4] always read 0, whatever was written to them.
- R4: Detection runs only for code 11. With codes 00, 01 or 10 the stop flag stays 0, even when the main clock is dead.
- R5: With code 11, the stop flag rises at the clock edge 18 cycles after the first edge at which the main-clock input is sampled high for the last time. This is 2 synchronizer cycles followed by 16 cycles without an edge.
- R6: The clock edge that raises the stop flag also sets clock-select to 1. At that edge `switch_pulse` goes high for exactly one cycle.
- R7: While the stop flag is 1, a write of 0 to clock-select is ignored and the bit stays 1. The detection code in the same write still applies.
- R8: The stop flag clears at the edge that consumes the 4th main-clock rising edge seen while it is set. Clock-select then stays 1 until software writes it to 0.
- R9: Writing a detection code other than 11 clears the stop flag one cycle after the write lands.
- R10: `osc_stop` is 0 whenever clock-select is 1. Otherwise it follows `osc_stop_req`.
- R11: A main clock with a rising edge every 4 cycles never raises the stop flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_clk_in | input | 1 | Raw main-clock level, sampled by the synchronizer |
| wr_en | input | 1 | Register write strobe |
| wr_unlock | input | 1 | Write protect gate; writes are accepted only when 1 |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value |
| sel_int_osc | output | 1 | Glitch-free clock select, 1 = internal oscillator |
| osc_stop_req | input | 1 | Request to stop the low-speed internal oscillator |
| osc_stop | output | 1 | Oscillator stop control after forcing |
| switch_pulse | output | 1 | One-cycle pulse on an automatic switchover |

## Verification
The bench builds the block with its default parameters: a 16-cycle timeout, 4 recovery edges and a 2-stage synchronizer. With these values a full trip, a recovery and a second trip all fit in a few dozen cycles, so the exact cycle of each event can be predicted and checked. Stimulus drives the main clock with a 4-cycle period and then stops it. This shows both the edge counting that keeps the flag low and the exact edge at which it rises. The bench also drives the reserved enable codes with a dead main clock, to show that they do not trip detection.

// File: rtl/osf_pkg.sv
package osf_pkg;
  localparam logic [1:0] DET_ON    = 2'b11;
  localparam int         SEL_BIT   = 2;
  localparam int         STOP_BIT  = 3;
  localparam logic [7:0] REG_RESET = 8'h04;

  typedef struct packed {
    logic [1:0] det_code;
    logic       sel_int;
  } osf_ctl_t;
endpackage

// File: rtl/osf_sync.sv
module osf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  for (genvar i = 0; i <= STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/osf_stop_det.sv
module osf_stop_det #(
  parameter int TIMEOUT_CYC   = 16,
  parameter int RECOVER_EDGES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic rise,
  output logic stop,
  output logic trip
);
  localparam int IW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam int RW = (RECOVER_EDGES > 1) ? $clog2(RECOVER_EDGES) : 1;
  localparam logic [IW-1:0] IDLE_LAST = IW'(TIMEOUT_CYC - 1);
  localparam logic [RW-1:0] REC_LAST  = RW'(RECOVER_EDGES - 1);

  logic [IW-1:0] idle_cnt;
  logic [RW-1:0] rec_cnt;
  logic          expire;

  assign expire = active && !rise && (idle_cnt == IDLE_LAST);
  assign trip   = expire && !stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
      rec_cnt  <= '0;
      stop     <= 1'b0;
    end else if (!active) begin
      idle_cnt <= '0;
      rec_cnt  <= '0;
      stop     <= 1'b0;
    end else if (rise) begin
      idle_cnt <= '0;
      if (stop) begin
        if (rec_cnt == REC_LAST) begin
          stop    <= 1'b0;
          rec_cnt <= '0;
        end else begin
          rec_cnt <= rec_cnt + 1'b1;
        end
      end
    end else if (expire) begin
      rec_cnt <= '0;
      stop    <= 1'b1;
    end else begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/osf_ctrl_reg.sv
module osf_ctrl_reg
  import osf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_unlock,
  input  logic [2:0] wr_bits,
  input  logic       trip,
  input  logic       stop,
  output osf_ctl_t   ctl,
  output logic       pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl.det_code <= REG_RESET[1:0];
      ctl.sel_int  <= REG_RESET[SEL_BIT];
      pulse        <= 1'b0;
    end else begin
      pulse <= trip;
      if (wr_en && wr_unlock) begin
        ctl.det_code <= wr_bits[1:0];
        ctl.sel_int  <= wr_bits[SEL_BIT] | stop;
      end
      if (trip) ctl.sel_int <= 1'b1;
    end
  end
endmodule

// File: rtl/osf_failover_top.sv
module osf_failover_top
  import osf_pkg::*;
#(
  parameter int TIMEOUT_CYC   = 16,
  parameter int RECOVER_EDGES = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       main_clk_in,
  input  logic       wr_en,
  input  logic       wr_unlock,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       sel_int_osc,
  input  logic       osc_stop_req,
  output logic       osc_stop,
  output logic       switch_pulse
);
  logic     rise;
  logic     stop;
  logic     trip;
  logic     det_active;
  osf_ctl_t ctl;
  logic     unused_rsv;

  assign unused_rsv = ^wr_data[7:3];

  osf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (main_clk_in),
    .rise (rise)
  );

  assign det_active = (ctl.det_code == DET_ON);

  osf_stop_det #(
    .TIMEOUT_CYC  (TIMEOUT_CYC),
    .RECOVER_EDGES(RECOVER_EDGES)
  ) u_det (
    .clk   (clk),
    .rst_n (rst_n),
    .active(det_active),
    .rise  (rise),
    .stop  (stop),
    .trip  (trip)
  );

  osf_ctrl_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_unlock(wr_unlock),
    .wr_bits  (wr_data[2:0]),
    .trip     (trip),
    .stop     (stop),
    .ctl      (ctl),
    .pulse    (switch_pulse)
  );

  always_comb begin
    rd_data           = 8'h00;
    rd_data[1:0]      = ctl.det_code;
    rd_data[SEL_BIT]  = ctl.sel_int;
    rd_data[STOP_BIT] = stop;
  end

  assign sel_int_osc = ctl.sel_int;
  assign osc_stop    = osc_stop_req & ~ctl.sel_int;
endmodule

// File: rtl/osf_failover_chk.sv
module osf_failover_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_unlock,
  input logic [7:0] rd_data,
  input logic       sel_int_osc,
  input logic       osc_stop,
  input logic       switch_pulse
);
  AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_unlock) |=> rd_data[1:0] == $past(rd_data[1:0])); // R2

  AST_STOP_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[3] |-> $past(rd_data[1:0]) == 2'b11); // R4

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse |=> !switch_pulse); // R6

  AST_PULSE_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pulse |-> (rd_data[3] && sel_int_osc)); // R6

  AST_SEL_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_int_osc) |-> (switch_pulse || $past(wr_en && wr_unlock))); // R6

  AST_STOP_HOLDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[3] |-> sel_int_osc); // R7

  AST_OSC_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    sel_int_osc |-> !osc_stop); // R10
endmodule

bind osf_failover_top osf_failover_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_unlock   (wr_unlock),
  .rd_data     (rd_data),
  .sel_int_osc (sel_int_osc),
  .osc_stop    (osc_stop),
  .switch_pulse(switch_pulse)
);

// File: tb/osf_failover_top_tb.sv
`timescale 1ns/1ps
module osf_failover_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       main_clk_in = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_unlock = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       sel_int_osc;
  logic       osc_stop_req = 1'b0;
  logic       osc_stop;
  logic       switch_pulse;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int last_rise = 0;
  bit done = 1'b0;

  typedef struct {
    int         at;
    logic [7:0] rd;
    logic       pulse;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  osf_failover_top u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .main_clk_in (main_clk_in),
    .wr_en       (wr_en),
    .wr_unlock   (wr_unlock),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .sel_int_osc (sel_int_osc),
    .osc_stop_req(osc_stop_req),
    .osc_stop    (osc_stop),
    .switch_pulse(switch_pulse)
  );

  task automatic expect_in(int dly, logic [7:0] rd, logic p, string tag);
    exp_t e;
    e.at = cyc + dly; e.rd = rd; e.pulse = p; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic do_write(logic [7:0] d, logic unl);
    wr_en = 1'b1; wr_data = d; wr_unlock = unl;
    @(negedge clk);
    wr_en = 1'b0; wr_unlock = 1'b0; wr_data = 8'h00;
  endtask

  task automatic main_pulses(int n);
    for (int i = 0; i < n; i++) begin
      main_clk_in = 1'b1; last_rise = cyc;
      repeat (2) @(negedge clk);
      main_clk_in = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  // monitor: pops expected items in cycle order and compares
  initial begin
    forever begin
      @(negedge clk); #1;
      while (q.size() > 0 && q[0].at <= cyc) begin
        exp_t e;
        logic exp_osc;
        e = q.pop_front();
        n_chk++;
        exp_osc = osc_stop_req & ~e.rd[2];
        if (e.at < cyc) begin
          n_fail++;
          $display("FAIL %s: item for cycle %0d missed at %0d", e.tag, e.at, cyc);
        end else if (rd_data !== e.rd || switch_pulse !== e.pulse ||
                     sel_int_osc !== e.rd[2] || osc_stop !== exp_osc) begin
          n_fail++;
          $display("FAIL %s @%0d: rd=%02h pulse=%b sel=%b osc=%b expected rd=%02h pulse=%b sel=%b osc=%b",
                   e.tag, cyc, rd_data, switch_pulse, sel_int_osc, osc_stop,
                   e.rd, e.pulse, e.rd[2], exp_osc);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // driver
  initial begin
    int d0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    expect_in(0, 8'h04, 1'b0, "R1 reset value");
    @(negedge clk);
    osc_stop_req = 1'b1;

    expect_in(1, 8'h04, 1'b0, "R2 locked write ignored");
    do_write(8'h03, 1'b0);

    expect_in(1, 8'h01, 1'b0, "R3 reserved bits read 0");
    do_write(8'hF1, 1'b1);
    expect_in(30, 8'h01, 1'b0, "R4 code 01 no detection, R10 osc follows");
    repeat (30) @(negedge clk);

    expect_in(1, 8'h02, 1'b0, "R4 write code 10");
    do_write(8'hF2, 1'b1);
    expect_in(25, 8'h02, 1'b0, "R4 code 10 no detection");
    repeat (25) @(negedge clk);

    expect_in(1, 8'h03, 1'b0, "R11 enable detection");
    expect_in(30, 8'h03, 1'b0, "R11 running clock no stop");
    do_write(8'h03, 1'b1);
    main_pulses(10);

    expect_in(last_rise + 18 - cyc, 8'h03, 1'b0, "R5 no flag one cycle early");
    expect_in(last_rise + 19 - cyc, 8'h0F, 1'b1, "R5 R6 flag, select and pulse");
    expect_in(last_rise + 20 - cyc, 8'h0F, 1'b0, "R6 pulse lasts one cycle");
    repeat (17) @(negedge clk);

    expect_in(1, 8'h0F, 1'b0, "R7 select clear ignored");
    do_write(8'h03, 1'b1);

    d0 = cyc;
    expect_in(14, 8'h0F, 1'b0, "R8 flag holds before 4th edge");
    expect_in(15, 8'h07, 1'b0, "R8 flag clears, select stays");
    main_pulses(4);
    expect_in(1, 8'h03, 1'b0, "R8 software clears select");
    do_write(8'h03, 1'b1);
    expect_in(d0 + 30 - cyc, 8'h03, 1'b0, "R5 retrip not early");
    expect_in(d0 + 31 - cyc, 8'h0F, 1'b1, "R6 second trip");
    expect_in(d0 + 32 - cyc, 8'h0F, 1'b0, "R6 second pulse ends");
    repeat (16) @(negedge clk);

    expect_in(1, 8'h0C, 1'b0, "R9 code 00 lands, flag still set");
    expect_in(2, 8'h04, 1'b0, "R9 flag cleared");
    do_write(8'h00, 1'b1);
    @(negedge clk);
    expect_in(1, 8'h00, 1'b0, "R10 select cleared, osc stop follows");
    do_write(8'h00, 1'b1);
    repeat (3) @(negedge clk);
    #2;

    if (q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL queue: %0d items left, expected 0", q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule